// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves branch instructions for an 8-bit processor core. Each clock it looks at one opcode together with the status flags, the address of the following instruction, a signed 8-bit displacement and, for bit-test branches, a zero-page data byte. One clock later it reports whether the branch is taken, the branch target address, and how many cycles beyond the base count the branch costs.

Three families of branch are recognised. The first is the eight conditional branches, each of which tests one status flag against a polarity. The second is the unconditional branch. The third is the sixteen bit-test branches, which test one bit of the supplied data byte for clear or set. A taken branch costs one extra cycle. A taken branch whose target lies in a different 256-byte page from the next instruction costs one more. The core fetches the operands and updates the program counter itself; this unit only decides and computes.

Top module: `br_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `taken_o`=0, `target_o`=0 and `extra_o`=0.
- R2: Flag branches are the opcodes 10h/30h (flag N, bit 7 of `flags_i`), 50h/70h (V, bit 6), 90h/B0h (C, bit 0) and D0h/F0h (Z, bit 1). The first of each pair is taken when the flag is 0 and the second when it is 1.
- R3: Opcode 80h is taken whatever the flags and data byte are.
- R4: Opcode 0Fh+10h*b, for b from 0 to 7, is taken exactly when bit b of `zp_byte_i` is 0.
- R5: Opcode 8Fh+10h*b, for b from 0 to 7, is taken exactly when bit b of `zp_byte_i` is 1.
- R6: `target_o` equals `next_pc_i` plus `disp_i` read as a two's-complement value, modulo 2^16. The target is computed for every opcode.
- R7: A taken branch whose target has the same high byte as `next_pc_i` reports `extra_o`=1.
- R8: A taken branch whose target has a different high byte from `next_pc_i` reports `extra_o`=2. This includes wrap-around past FFFFh or below 0000h.
- R9: A branch opcode that is not taken reports `extra_o`=0.
- R10: Every opcode outside R2 to R5 reports `taken_o`=0 and `extra_o`=0.
- R11: The outputs reflect the inputs sampled at the previous rising edge of `clk`. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 8 | Opcode byte |
| flags_i | input | 8 | Status flags (N=7, V=6, Z=1, C=0) |
| next_pc_i | input | 16 | Address of the following instruction |
| disp_i | input | 8 | Signed displacement |
| zp_byte_i | input | 8 | Zero-page byte tested by bit branches |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch target address |
| extra_o | output | 2 | Extra cycles beyond the base count |

## Verification
Suppose the decoded kind, the flag select or the polarity goes wrong. Then `taken_o` flips for that opcode one cycle after it is presented. Because `extra_o` is derived from the taken decision, a flipped decision also shows up in the cycle count. A wrong page comparison or a wrong sign extension is visible in the same cycle, as a wrong `extra_o` or `target_o` on targets that cross a page or wrap. For this reason the stimulus covers every branch opcode against both flag and bit values, and includes backward and wrapping displacements.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int FLAG_N = 7;
    localparam int FLAG_V = 6;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_FLAG,
        BK_ALWAYS,
        BK_BIT_CLR,
        BK_BIT_SET
    } br_kind_e;

    typedef struct packed {
        br_kind_e    kind;
        logic [1:0]  flag_sel;   // 0:N 1:V 2:C 3:Z
        logic        want;       // required flag value
        logic [2:0]  bit_idx;
    } br_dec_t;

    typedef struct packed {
        logic        taken;
        logic [1:0]  extra;
    } br_cost_t;

    function automatic logic pick_flag(input logic [7:0] f, input logic [1:0] sel);
        case (sel)
            2'd0:    pick_flag = f[FLAG_N];
            2'd1:    pick_flag = f[FLAG_V];
            2'd2:    pick_flag = f[FLAG_C];
            default: pick_flag = f[FLAG_Z];
        endcase
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] op,
    output br_dec_t    dec
);
    always_comb begin
        dec          = '0;
        dec.kind     = BK_NONE;
        dec.flag_sel = op[7:6];
        dec.want     = op[5];
        dec.bit_idx  = op[6:4];
        if (op == 8'h80) begin
            dec.kind = BK_ALWAYS;
        end else if (op[3:0] == 4'h0 && op[4]) begin
            dec.kind = BK_FLAG;
        end else if (op[3:0] == 4'hF) begin
            dec.kind = op[7] ? BK_BIT_SET : BK_BIT_CLR;
        end
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  br_dec_t           dec,
    input  logic [7:0]        flags,
    input  logic [DATA_W-1:0] zp_byte,
    output logic              taken
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] bit_hit;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_sel
            assign bit_hit[gi] = (dec.bit_idx[IDX_W-1:0] == IDX_W'(gi)) & zp_byte[gi];
        end
    endgenerate

    logic bit_val;
    assign bit_val = |bit_hit;

    always_comb begin
        case (dec.kind)
            BK_ALWAYS:  taken = 1'b1;
            BK_FLAG:    taken = (pick_flag(flags, dec.flag_sel) == dec.want);
            BK_BIT_CLR: taken = ~bit_val;
            BK_BIT_SET: taken = bit_val;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic              crossed
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign target   = next_pc + disp_ext;
    assign crossed  = target[ADDR_W-1:PAGE_W] != next_pc[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        op_i,
    input  logic [7:0]        flags_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [DATA_W-1:0] zp_byte_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [1:0]        extra_o
);
    br_dec_t           dec;
    logic              take_c;
    logic              cross_c;
    logic [ADDR_W-1:0] tgt_c;
    br_cost_t          cost_c;
    br_cost_t          cost_q;
    logic [ADDR_W-1:0] tgt_q;

    br_decode u_dec (.op(op_i), .dec(dec));

    br_cond #(.DATA_W(DATA_W)) u_cond (
        .dec(dec), .flags(flags_i), .zp_byte(zp_byte_i), .taken(take_c)
    );

    br_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_tgt (
        .next_pc(next_pc_i), .disp(disp_i), .target(tgt_c), .crossed(cross_c)
    );

    always_comb begin
        cost_c.taken = take_c;
        cost_c.extra = take_c ? (cross_c ? 2'd2 : 2'd1) : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cost_q <= '0;
            tgt_q  <= '0;
        end else begin
            cost_q <= cost_c;
            tgt_q  <= tgt_c;
        end
    end

    assign taken_o  = cost_q.taken;
    assign extra_o  = cost_q.extra;
    assign target_o = tgt_q;
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        op_i,
    input logic [ADDR_W-1:0] next_pc_i,
    input logic [DISP_W-1:0] disp_i,
    input logic              taken_o,
    input logic [ADDR_W-1:0] target_o,
    input logic [1:0]        extra_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    a_r9_idle_free: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> extra_o == 2'd0);

    a_r7_taken_costs: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (extra_o == 2'd1 || extra_o == 2'd2));

    a_r3_always: assert property (@(posedge clk) disable iff (rst)
        (op_i == 8'h80) |=> taken_o);

    a_r10_other_low: assert property (@(posedge clk) disable iff (rst)
        (op_i[3:0] != 4'h0 && op_i[3:0] != 4'hF) |=> (!taken_o && extra_o == 2'd0));

    a_r10_even_col: assert property (@(posedge clk) disable iff (rst)
        (op_i[3:0] == 4'h0 && !op_i[4] && op_i != 8'h80) |=> !taken_o);

    a_r6_target: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> target_o == $past(next_pc_i) + {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)});

    a_r8_cross: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!taken_o
                  || target_o[ADDR_W-1:PAGE_W] == $past(next_pc_i[ADDR_W-1:PAGE_W])
                  || extra_o == 2'd2));
endmodule

bind br_unit br_unit_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .next_pc_i(next_pc_i), .disp_i(disp_i),
    .taken_o(taken_o), .target_o(target_o), .extra_o(extra_o)
);

// File: tb/sim_br_unit.sv
module sim_br_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_i = 8'h00;
    logic [7:0]  flags_i = 8'h00;
    logic [15:0] next_pc_i = 16'h0000;
    logic [7:0]  disp_i = 8'h00;
    logic [7:0]  zp_byte_i = 8'h00;
    logic        taken_o;
    logic [15:0] target_o;
    logic [1:0]  extra_o;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        bit    tk;
        int    tg;
        int    ex;
        string tag;
    } exp_t;

    exp_t pend[$];

    always #10 clk = ~clk;

    br_unit u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .flags_i(flags_i), .next_pc_i(next_pc_i),
        .disp_i(disp_i), .zp_byte_i(zp_byte_i), .taken_o(taken_o), .target_o(target_o),
        .extra_o(extra_o)
    );

    function automatic exp_t model(input int op, input int fl, input int npc,
                                   input int d, input int zb, input string tag);
        exp_t e;
        int lo = op % 16;
        int hi = op / 16;
        int sd = (d >= 128) ? d - 256 : d;
        e.tk = 0;
        if (op == 128) e.tk = 1;
        else if (lo == 0 && (hi % 2) == 1) begin
            case (hi)
                1:  e.tk = ((fl >> 7) & 1) == 0;
                3:  e.tk = ((fl >> 7) & 1) == 1;
                5:  e.tk = ((fl >> 6) & 1) == 0;
                7:  e.tk = ((fl >> 6) & 1) == 1;
                9:  e.tk = (fl & 1) == 0;
                11: e.tk = (fl & 1) == 1;
                13: e.tk = ((fl >> 1) & 1) == 0;
                default: e.tk = ((fl >> 1) & 1) == 1;
            endcase
        end else if (lo == 15) begin
            int b = hi % 8;
            int v = (zb >> b) & 1;
            e.tk = (hi < 8) ? (v == 0) : (v == 1);
        end
        e.tg = (npc + sd + 65536) % 65536;
        e.ex = e.tk ? (((e.tg / 256) != (npc / 256)) ? 2 : 1) : 0;
        e.tag = tag;
        return e;
    endfunction

    task automatic check_pending();
        if (pend.size() > 0) begin
            exp_t e = pend.pop_front();
            n_run++;
            if (taken_o !== e.tk || int'(target_o) != e.tg || int'(extra_o) != e.ex) begin
                n_fail++;
                $display("FAIL %s: taken=%0b target=%04h extra=%0d expected taken=%0b target=%04h extra=%0d",
                         e.tag, taken_o, target_o, extra_o, e.tk, e.tg[15:0], e.ex);
            end
        end
    endtask

    task automatic step(input int op, input int fl, input int npc, input int d,
                        input int zb, input string tag);
        @(negedge clk);
        check_pending();
        op_i      = op[7:0];
        flags_i   = fl[7:0];
        next_pc_i = npc[15:0];
        disp_i    = d[7:0];
        zp_byte_i = zb[7:0];
        pend.push_back(model(op, fl, npc, d, zb, tag));
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        op_i = 8'h80;
        repeat (3) @(negedge clk);
        // R1: reset values, even with a taken opcode presented
        n_run++;
        if (taken_o !== 1'b0 || target_o !== 16'h0000 || extra_o !== 2'd0) begin
            n_fail++;
            $display("FAIL R1: taken=%0b target=%04h extra=%0d expected 0/0000/0", taken_o, target_o, extra_o);
        end
        rst = 1'b0;

        // R2: every flag opcode with its flag clear and set
        for (int k = 0; k < 8; k++) begin
            int opc = 16 + 32 * k;
            step(opc, 8'h00, 16'h1200, 8'h10, 0, "R2");
            step(opc, 8'hFF, 16'h1200, 8'h10, 0, "R2");
            step(opc, 8'h3C, 16'h1200, 8'h10, 0, "R2");
            step(opc, 8'hC3, 16'h1200, 8'h10, 0, "R2");
        end
        // R3: always branch regardless of inputs
        step(8'h80, 8'h00, 16'h4000, 8'h05, 8'h00, "R3");
        step(8'h80, 8'hFF, 16'h4000, 8'h05, 8'hFF, "R3");
        // R4 / R5: bit tests against one-hot and inverted patterns
        for (int b = 0; b < 8; b++) begin
            step(15 + 16 * b, 1 << b, 16'h2000, 8'h08, 1 << b, "R4");
            step(15 + 16 * b, 0, 16'h2000, 8'h08, 255 - (1 << b), "R4");
            step(143 + 16 * b, 0, 16'h2000, 8'h08, 1 << b, "R5");
            step(143 + 16 * b, 0, 16'h2000, 8'h08, 255 - (1 << b), "R5");
        end
        // R6/R7/R8: same page, forward and backward crossings, wraps
        step(8'h80, 0, 16'h30F0, 8'h0F, 0, "R7");
        step(8'h80, 0, 16'h30F0, 8'h10, 0, "R8");
        step(8'h80, 0, 16'h3005, 8'hFB, 0, "R7");
        step(8'h80, 0, 16'h3005, 8'hFA, 0, "R8");
        step(8'h80, 0, 16'hFFF0, 8'h7F, 0, "R8");
        step(8'h80, 0, 16'h0010, 8'h80, 0, "R8");
        step(8'h80, 0, 16'h5555, 8'h00, 0, "R6");
        // R9: not-taken crossing branch costs nothing
        step(8'hF0, 8'h00, 16'h30F0, 8'h40, 0, "R9");
        // R10: non-branch opcodes
        step(8'h00, 8'hFF, 16'h30F0, 8'h40, 8'hFF, "R10");
        step(8'h20, 8'hFF, 16'h30F0, 8'h40, 8'hFF, "R10");
        step(8'hEA, 8'hFF, 16'h30F0, 8'h40, 8'hFF, "R10");
        step(8'h8A, 8'h00, 16'h30F0, 8'h40, 8'h00, "R10");
        step(8'hDB, 8'h00, 16'h30F0, 8'h40, 8'h00, "R10");
        // R11: random back-to-back stream, each result one cycle later
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 4;
            int opc = (r == 0) ? ($urandom % 256) : (r == 1) ? (16 * ($urandom % 16) + 15)
                    : (r == 2) ? (16 + 32 * ($urandom % 8)) : 128;
            step(opc, $urandom % 256, $urandom % 65536, $urandom % 256, $urandom % 256, "R11");
        end
        // R1: reset in mid-stream clears outputs
        @(negedge clk);
        check_pending();
        op_i = 8'h80;
        rst = 1'b1;
        @(negedge clk);
        n_run++;
        if (taken_o !== 1'b0 || target_o !== 16'h0000 || extra_o !== 2'd0) begin
            n_fail++;
            $display("FAIL R1: taken=%0b target=%04h extra=%0d expected 0/0000/0", taken_o, target_o, extra_o);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule